// File: doc/BRIEF.md
# Gated Clock Inverter

This block produces an inverted copy of a clock that is qualified by a gate signal, and it keeps its own output gate alongside it. On every edge of a fast sampling clock it looks at the incoming clock level and the incoming gate. It drives its output low when both are high and drives it high otherwise. Its stored gate can close the output, and while that gate is closed the output stays low. The stored gate takes a new value from the incoming gate only in cycles where the new output level is low. Changes of the gate therefore reach the output only in its low phase.

The level, the stored gate and two edge pulses are all registered on the sampling clock. A downstream consumer can therefore treat the rising and falling pulses as single-cycle event strobes. A ready output is tied high. The reset value of the stored gate is a parameter, open by default. When the gate resets open, the incoming gate can never close it, because the output can only go low while the incoming gate is high. A closed reset value lets the output start silenced until the first gate sample.

Top module: `gated_clk_inverter`

## Requirements
- R1: While the stored gate is 1, the output level after a sampling edge is 0 if both clock input and gate input were 1 at that edge, and 1 otherwise.
- R2: While the stored gate is 0, the output level after the next sampling edge is 0 whatever the clock and gate inputs are.
- R3: The rising pulse is 1 for exactly the one cycle in which the output level has just changed from 0 to 1, and 0 in every other cycle.
- R4: The falling pulse is 1 for exactly the one cycle in which the output level has just changed from 1 to 0, and 0 in every other cycle.
- R5: At a sampling edge where the new output level is 0, the stored gate takes the gate input's value. Where the new level is 1, the stored gate keeps its value.
- R6: A sampling edge with reset low sets the output level to 0, the stored gate to the INIT_GATE parameter (default 1), and both pulses to 0.
- R7: The ready output is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_in | input | 1 | Incoming clock level |
| gate_in | input | 1 | Incoming gate |
| clk_out | output | 1 | Registered inverted, gated output level |
| gate_out | output | 1 | Stored output gate |
| rise_pulse | output | 1 | One-cycle strobe on a 0-to-1 output change |
| fall_pulse | output | 1 | One-cycle strobe on a 1-to-0 output change |
| ready | output | 1 | Constant 1 |

## Verification
A square wave on the clock input with the gate held high checks plain inversion and the alternating rise and fall strobes. Holding the gate low while the clock input keeps toggling shows that the output stays high and that the stored gate is not refreshed during the high phase. Toggling the gate under a steady high clock input separates the gate from the clock in the AND term. A pseudo-random stream on both inputs goes to a second instance whose gate resets closed, and this reveals whether the force-low path and the low-phase-only gate refresh act in the right cycles.

// File: rtl/gci_pkg.sv
// Shared types of the gated clock inverter.
package gci_pkg;
    // Pair of single-cycle edge strobes for the output level.
    typedef struct packed {
        logic rise;
        logic fall;
    } gci_edge_t;

    localparam logic LEVEL_AT_RESET = 1'b0;
endpackage

// File: rtl/gci_level.sv
// gci_level: works out the output level for the next sampling edge.
// Assumes gate_open is the registered stored gate. Purely combinational.
module gci_level (
    input  logic clk_in,
    input  logic gate_in,
    input  logic gate_open,
    output logic next_level
);
    logic candidate;

    // Inverted AND of clock and gate, forced low when the stored gate is shut.
    always_comb begin
        candidate  = !(clk_in && gate_in);
        next_level = gate_open ? candidate : 1'b0;
    end
endmodule

// File: rtl/gci_gate_hold.sv
// gci_gate_hold: stores the output gate. It reloads from the incoming gate
// only when the level being registered is low.
// Assumes a synchronous active-low reset.
module gci_gate_hold #(
    parameter logic INIT_GATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic next_level,
    input  logic gate_in,
    output logic gate_q
);
    // Reload the stored gate during the low phase only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= INIT_GATE;
        else if (!next_level)
            gate_q <= gate_in;
    end
endmodule

// File: rtl/gci_edge_track.sv
// gci_edge_track: registers the output level and flags its changes as
// one-cycle rise and fall strobes. Assumes a synchronous active-low reset.
module gci_edge_track
    import gci_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      next_level,
    output logic      level_q,
    output gci_edge_t edges_q
);
    // Register the level and compare it with the one it replaces.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LEVEL_AT_RESET;
            edges_q <= '0;
        end else begin
            level_q      <= next_level;
            edges_q.rise <= next_level && !level_q;
            edges_q.fall <= !next_level && level_q;
        end
    end
endmodule

// File: rtl/gated_clk_inverter.sv
// gated_clk_inverter: sampled model of a gated clock inverter. The output
// is the inverse of (clk_in AND gate_in), held low while the stored gate is
// shut. All outputs are registered on clk. Assumes that clk samples clk_in
// fast enough to see every phase.
module gated_clk_inverter
    import gci_pkg::*;
#(
    parameter logic INIT_GATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_in,
    input  logic gate_in,
    output logic clk_out,
    output logic gate_out,
    output logic rise_pulse,
    output logic fall_pulse,
    output logic ready
);
    logic      next_level;
    logic      gate_q;
    logic      level_q;
    gci_edge_t edges_q;

    gci_level u_level (
        .clk_in     (clk_in),
        .gate_in    (gate_in),
        .gate_open  (gate_q),
        .next_level (next_level)
    );

    gci_gate_hold #(.INIT_GATE(INIT_GATE)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_level (next_level),
        .gate_in    (gate_in),
        .gate_q     (gate_q)
    );

    gci_edge_track u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_level (next_level),
        .level_q    (level_q),
        .edges_q    (edges_q)
    );

    // Drive the ports from the registered state.
    always_comb begin
        clk_out    = level_q;
        gate_out   = gate_q;
        rise_pulse = edges_q.rise;
        fall_pulse = edges_q.fall;
        ready      = 1'b1;
    end
endmodule

// File: rtl/gci_checker.sv
// gci_checker: port-level properties of gated_clk_inverter, bound to it.
module gci_checker #(
    parameter logic INIT_GATE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic clk_in,
    input logic gate_in,
    input logic clk_out,
    input logic gate_out,
    input logic rise_pulse,
    input logic fall_pulse,
    input logic ready
);
    assert_invert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gate_out)) |-> (clk_out == !($past(clk_in) && $past(gate_in))));

    assert_forced_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(gate_out)) |-> !clk_out);

    assert_rise_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rise_pulse == (clk_out && !$past(clk_out))));

    assert_fall_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fall_pulse == (!clk_out && $past(clk_out))));

    assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && clk_out) |-> $stable(gate_out));

    assert_gate_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !clk_out) |-> (gate_out == $past(gate_in)));

    assert_reset_state_R6: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (!clk_out && gate_out == INIT_GATE && !rise_pulse && !fall_pulse));

    assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n) ready);
endmodule

bind gated_clk_inverter gci_checker #(.INIT_GATE(INIT_GATE)) u_gci_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_in     (clk_in),
    .gate_in    (gate_in),
    .clk_out    (clk_out),
    .gate_out   (gate_out),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .ready      (ready)
);

// File: tb/gated_clk_inverter_bench.sv
module gated_clk_inverter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_in = 1'b0;
    logic gate_in = 1'b0;
    logic [1:0] o_lvl, o_gate, o_rise, o_fall, o_rdy;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state for the two instances (index 1: gate resets shut).
    int m_lvl [2];
    int m_gate[2];
    int m_rise[2];
    int m_fall[2];
    int m_prev_gate[2];
    int init_gate[2] = '{1, 0};

    always #5 clk = ~clk;

    gated_clk_inverter u_gated_clk_inverter (
        .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .gate_in(gate_in),
        .clk_out(o_lvl[0]), .gate_out(o_gate[0]), .rise_pulse(o_rise[0]),
        .fall_pulse(o_fall[0]), .ready(o_rdy[0])
    );

    gated_clk_inverter #(.INIT_GATE(1'b0)) u_gated_clk_inverter_shut (
        .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .gate_in(gate_in),
        .clk_out(o_lvl[1]), .gate_out(o_gate[1]), .rise_pulse(o_rise[1]),
        .fall_pulse(o_fall[1]), .ready(o_rdy[1])
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cycles, got, exp);
        end
    endtask

    // Advance the reference by one sampling edge.
    task automatic model_edge(input int i, input int r, input int ci, input int gi);
        int nl;
        m_prev_gate[i] = m_gate[i];
        if (r == 0) begin
            m_lvl[i] = 0; m_gate[i] = init_gate[i]; m_rise[i] = 0; m_fall[i] = 0;
        end else begin
            nl = (m_gate[i] != 0) ? ((ci != 0 && gi != 0) ? 0 : 1) : 0;
            m_rise[i] = (nl == 1 && m_lvl[i] == 0) ? 1 : 0;
            m_fall[i] = (nl == 0 && m_lvl[i] == 1) ? 1 : 0;
            if (nl == 0) m_gate[i] = gi;
            m_lvl[i] = nl;
        end
    endtask

    // Apply one input pair, let one edge pass, compare every output.
    task automatic step(input int r, input int ci, input int gi);
        rst_n = r[0]; clk_in = ci[0]; gate_in = gi[0];
        @(posedge clk);
        for (int i = 0; i < 2; i++) model_edge(i, r, ci, gi);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            if (r == 0) begin
                check("R6 level", o_lvl[i], 0);
                check("R6 gate", o_gate[i], init_gate[i]);
                check("R6 pulses", {o_rise[i], o_fall[i]}, 0);
            end else begin
                if (m_prev_gate[i] != 0) check("R1 level", o_lvl[i], m_lvl[i]);
                else check("R2 level", o_lvl[i], m_lvl[i]);
                check("R3 rise", o_rise[i], m_rise[i]);
                check("R4 fall", o_fall[i], m_fall[i]);
                check("R5 gate", o_gate[i], m_gate[i]);
            end
            check("R7 ready", o_rdy[i], 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr = 8'hA5;
        @(negedge clk);
        for (int k = 0; k < 3; k++) step(0, k % 2, 1);
        // Square wave on the clock input with the gate open.
        for (int k = 0; k < 20; k++) step(1, k % 2, 1);
        // Gate low while the clock input toggles.
        for (int k = 0; k < 12; k++) step(1, (k / 2) % 2, 0);
        // Gate toggles with the clock input held high.
        for (int k = 0; k < 12; k++) step(1, 1, (k / 3) % 2);
        // Pseudo-random stream on both inputs.
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1, lfsr[0], lfsr[3] | lfsr[6]);
        end
        // Reset in mid-run, then resume.
        step(0, 1, 1);
        step(0, 0, 0);
        for (int k = 0; k < 10; k++) step(1, k % 2, k % 3 != 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule